// File: doc/BRIEF.md
# Dual Countdown Timers with Gated Tone Output

This block provides two 8-bit countdown timers of the sort that a small game interpreter needs: a general delay timer and a sound timer. The host loads either timer through its own load strobe and data bus, and can read both current values at any time. A shared divider derives a frame tick (60 Hz at the default parameters) from the system clock, and on every tick each timer that holds a non-zero value drops by one. A timer that reaches zero stays there.

The sound timer gates a square-wave tone. While the sound timer holds a non-zero value, the `beep` output toggles at a rate picked by a 2-bit tone code, which the host writes through a write-only register. When the sound timer is zero the output sits low and the tone generator returns to its starting phase, so every beep starts with a full low half-period.

Top module: `cdtimer_beeper`

## Requirements
- R1: While `rst_n` is low, both timer values read 0, `beep` is low and the stored tone code is 0.
- R2: A cycle with a load strobe high sets that timer to the load data at the next clock edge.
- R3: On a frame tick, each timer without a load in that cycle and holding a non-zero value decreases by exactly one.
- R4: A timer holding 0 stays 0 on a tick; it never wraps to the maximum value.
- R5: A load that lands in the same cycle as a frame tick wins: the timer takes the load data, not the decremented value.
- R6: Loading one timer leaves the other timer's value unchanged.
- R7: Frame ticks occur once every `TICK_DIV` clock cycles, the first one on the `TICK_DIV`-th rising edge after reset is released.
- R8: `beep` is low in every cycle in which the sound timer value is 0.
- R9: While the sound timer is non-zero, `beep` changes level once every H cycles, where tone codes 0, 1, 2 and 3 select H = `HALF0`, `HALF1`, `HALF2` and `HALF3`; `beep` starts low when the sound timer becomes non-zero.
- R10: A tone-code write (`tone_wr` high) stores `tone_code` for use from the next cycle and does not change either timer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dly_load | input | 1 | Load strobe for the delay timer |
| dly_data | input | TMR_W | Value loaded into the delay timer |
| snd_load | input | 1 | Load strobe for the sound timer |
| snd_data | input | TMR_W | Value loaded into the sound timer |
| tone_wr | input | 1 | Write strobe for the tone code register |
| tone_code | input | 2 | Tone code written when `tone_wr` is high |
| dly_value | output | TMR_W | Current delay timer value |
| snd_value | output | TMR_W | Current sound timer value |
| beep | output | 1 | Square-wave audio bit, low while the sound timer is 0 |

## Verification
The hardest case to reach from the ports is a load arriving in exactly the cycle of a frame tick, because the tick is internal and never leaves the block. The bench keeps its own count of cycles since reset, derived from the tick period, waits until that count says the next edge carries a tick, and then raises both load strobes together. Constrained random loads biased toward 0, 1 and 255, mixed with random tone-code changes while the beep is running, then cover saturation and tone switching mid-period.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

  typedef enum logic [1:0] {
    TONE_LOW  = 2'd0,
    TONE_MID  = 2'd1,
    TONE_HIGH = 2'd2,
    TONE_TOP  = 2'd3
  } tone_code_e;

  // Next value of a countdown register: load wins, then a saturating step.
  function automatic int unsigned tmr_next(input int unsigned cur,
                                           input logic ld,
                                           input int unsigned din,
                                           input logic tick);
    if (ld) return din;
    if (tick && cur != 0) return cur - 1;
    return cur;
  endfunction

  // Half-period in clock cycles for a given tone code.
  function automatic int unsigned tone_half(input logic [1:0] code,
                                            input int unsigned h0,
                                            input int unsigned h1,
                                            input int unsigned h2,
                                            input int unsigned h3);
    case (code)
      2'd0:    return h0;
      2'd1:    return h1;
      2'd2:    return h2;
      default: return h3;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c,
                                       input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ctb_tick_gen.sv
module ctb_tick_gen #(
  parameter int unsigned DIV = 833333
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  // R7: a tick is a single-cycle pulse, followed by a restarted count
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/ctb_countdown.sv
module ctb_countdown #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] val
);
  import ctb_pkg::*;

  logic [W-1:0] nxt;
  logic         dec_ev;

  assign dec_ev = tick && !load && (val != '0);
  assign nxt    = W'(tmr_next(int'(val), load, int'(din), tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= '0;
    else        val <= nxt;
  end

  // R2: a load is visible after one edge
  a_r2_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (val == $past(din)));
  // R3: a decrement step is exactly one
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ev |=> (val == $past(val) - W'(1)));
  // R4: zero is sticky without a load
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && val == '0) |=> (val == '0));
  // R5: load beats a coincident tick
  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && load) |=> (val == $past(din)));
  // R3: without tick or load nothing moves
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(val));

endmodule

// File: rtl/ctb_tone_gen.sv
module ctb_tone_gen #(
  parameter int unsigned CW    = 18,
  parameter int unsigned HALF0 = 113636,
  parameter int unsigned HALF1 = 56818,
  parameter int unsigned HALF2 = 28409,
  parameter int unsigned HALF3 = 14204
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       code_wr,
  input  logic [1:0] code_in,
  output logic       beep
);
  import ctb_pkg::*;

  logic [1:0]    code_q;
  logic [CW-1:0] tcnt_q;
  logic          ph_q;
  int unsigned   half;
  logic          wrap_ev;

  assign half    = tone_half(code_q, HALF0, HALF1, HALF2, HALF3);
  assign wrap_ev = active && ((int'(tcnt_q) + 1) >= half);
  assign beep    = ph_q && active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= TONE_LOW;
    else if (code_wr) code_q <= code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      ph_q   <= 1'b0;
    end else if (!active) begin
      tcnt_q <= '0;
      ph_q   <= 1'b0;
    end else if (wrap_ev) begin
      tcnt_q <= '0;
      ph_q   <= ~ph_q;
    end else begin
      tcnt_q <= tcnt_q + CW'(1);
    end
  end

  // R8: silence returns the phase to low
  a_r8_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !ph_q);
  // R9: phase flips only on a wrap event
  a_r9_flip_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (ph_q != $past(ph_q)));
  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wrap_ev) |=> $stable(ph_q));
  // R10: tone code is captured on write
  a_r10_code_capture: assert property (@(posedge clk) disable iff (!rst_n)
    code_wr |=> (code_q == $past(code_in)));

endmodule

// File: rtl/cdtimer_beeper.sv
module cdtimer_beeper #(
  parameter int unsigned TMR_W    = 8,
  parameter int unsigned TICK_DIV = 833333,
  parameter int unsigned HALF0    = 113636,
  parameter int unsigned HALF1    = 56818,
  parameter int unsigned HALF2    = 28409,
  parameter int unsigned HALF3    = 14204
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dly_load,
  input  logic [TMR_W-1:0] dly_data,
  input  logic             snd_load,
  input  logic [TMR_W-1:0] snd_data,
  input  logic             tone_wr,
  input  logic [1:0]       tone_code,
  output logic [TMR_W-1:0] dly_value,
  output logic [TMR_W-1:0] snd_value,
  output logic             beep
);
  import ctb_pkg::*;

  localparam int unsigned N_TMR    = 2;
  localparam int unsigned IDX_SND  = 1;
  localparam int unsigned HALF_MAX = max4(HALF0, HALF1, HALF2, HALF3);
  localparam int unsigned TONE_CW  = $clog2(HALF_MAX + 1) + 1;

  logic             frame_tick;
  logic             ld_v  [N_TMR];
  logic [TMR_W-1:0] din_v [N_TMR];
  logic [TMR_W-1:0] val_v [N_TMR];
  logic             snd_active;

  assign ld_v[0]  = dly_load;
  assign din_v[0] = dly_data;
  assign ld_v[1]  = snd_load;
  assign din_v[1] = snd_data;

  ctb_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_o(frame_tick)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    ctb_countdown #(.W(TMR_W)) u_cd (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (frame_tick),
      .load (ld_v[i]),
      .din  (din_v[i]),
      .val  (val_v[i])
    );
  end

  assign dly_value  = val_v[0];
  assign snd_value  = val_v[IDX_SND];
  assign snd_active = (snd_value != '0);

  ctb_tone_gen #(
    .CW   (TONE_CW),
    .HALF0(HALF0),
    .HALF1(HALF1),
    .HALF2(HALF2),
    .HALF3(HALF3)
  ) u_tone (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (snd_active),
    .code_wr(tone_wr),
    .code_in(tone_code),
    .beep   (beep)
  );

  // R8: the output bit is never high with an empty sound timer
  a_r8_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_value == '0) |-> !beep);
  // R6: a load of one timer alone leaves the other where a tick would put it
  a_r6_dly_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_load && !dly_load && !frame_tick) |=> $stable(dly_value));
  a_r6_snd_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_load && !snd_load && !frame_tick) |=> $stable(snd_value));

endmodule

// File: tb/tb_cdtimer_beeper.sv
module tb_cdtimer_beeper;
  localparam int DIV = 6;
  localparam int H0 = 2, H1 = 3, H2 = 5, H3 = 7;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dly_load, snd_load, tone_wr;
  logic [7:0] dly_data, snd_data;
  logic [1:0] tone_code;
  logic [7:0] dly_value, snd_value;
  logic       beep;

  always #10 clk = ~clk;

  cdtimer_beeper #(
    .TMR_W(8), .TICK_DIV(DIV), .HALF0(H0), .HALF1(H1), .HALF2(H2), .HALF3(H3)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .dly_load(dly_load), .dly_data(dly_data),
    .snd_load(snd_load), .snd_data(snd_data),
    .tone_wr(tone_wr), .tone_code(tone_code),
    .dly_value(dly_value), .snd_value(snd_value), .beep(beep)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;
  int cyc = 0;

  function automatic int exp_half(input int code);
    if (code == 0) return H0;
    if (code == 1) return H1;
    if (code == 2) return H2;
    return H3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model written from the requirements
  int m_cnt, m_dly, m_snd, m_sel, m_tcnt;
  bit m_ph;
  wire m_tick = (m_cnt == DIV - 1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_dly <= 0; m_snd <= 0; m_sel <= 0; m_tcnt <= 0; m_ph <= 1'b0;
    end else begin
      m_cnt <= m_tick ? 0 : m_cnt + 1;
      m_dly <= dly_load ? int'(dly_data) : ((m_tick && m_dly != 0) ? m_dly - 1 : m_dly);
      m_snd <= snd_load ? int'(snd_data) : ((m_tick && m_snd != 0) ? m_snd - 1 : m_snd);
      if (tone_wr) m_sel <= int'(tone_code);
      if (m_snd == 0) begin
        m_tcnt <= 0; m_ph <= 1'b0;
      end else if (m_tcnt >= exp_half(m_sel) - 1) begin
        m_tcnt <= 0; m_ph <= !m_ph;
      end else begin
        m_tcnt <= m_tcnt + 1;
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // Continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      check(int'(dly_value) == m_dly, "R3 delay timer", int'(dly_value), m_dly);
      check(int'(snd_value) == m_snd, "R3 sound timer", int'(snd_value), m_snd);
      check(beep == (m_ph && m_snd != 0), "R9 beep level", int'(beep), int'(m_ph && m_snd != 0));
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    wait (cyc >= WATCHDOG);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
    finish_run();
  end

  task automatic load_dly(input int v);
    dly_load = 1'b1; dly_data = 8'(v);
    @(negedge clk);
    dly_load = 1'b0;
  endtask

  task automatic load_snd(input int v);
    snd_load = 1'b1; snd_data = 8'(v);
    @(negedge clk);
    snd_load = 1'b0;
  endtask

  task automatic wait_beep_change(output int span);
    logic prev;
    prev = beep;
    span = 0;
    while (beep == prev && span < 1000) begin
      @(negedge clk);
      span++;
    end
  endtask

  initial begin
    int saved, span, t0;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    dly_load = 1'b0; snd_load = 1'b0; tone_wr = 1'b0;
    dly_data = '0; snd_data = '0; tone_code = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dly_value == 8'd0, "R1 delay reset", int'(dly_value), 0);
    check(snd_value == 8'd0, "R1 sound reset", int'(snd_value), 0);
    check(beep == 1'b0, "R1 beep reset", int'(beep), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);

    // R2: plain load
    while (m_tick) @(negedge clk);
    load_dly(3);
    check(dly_value == 8'd3, "R2 load value", int'(dly_value), 3);

    // R5: load on the tick cycle
    while (!m_tick) @(negedge clk);
    dly_load = 1'b1; dly_data = 8'd9;
    snd_load = 1'b1; snd_data = 8'd4;
    @(negedge clk);
    dly_load = 1'b0; snd_load = 1'b0;
    check(dly_value == 8'd9, "R5 delay load wins", int'(dly_value), 9);
    check(snd_value == 8'd4, "R5 sound load wins", int'(snd_value), 4);

    // R6: load of the sound timer alone
    while (m_tick) @(negedge clk);
    saved = int'(dly_value);
    load_snd(77);
    check(int'(dly_value) == saved, "R6 delay untouched", int'(dly_value), saved);
    check(snd_value == 8'd77, "R6 sound loaded", int'(snd_value), 77);

    // R4: saturation at zero
    load_dly(1);
    load_snd(0);
    repeat (3 * DIV) @(negedge clk);
    check(dly_value == 8'd0, "R4 delay stays zero", int'(dly_value), 0);
    check(snd_value == 8'd0, "R4 sound stays zero", int'(snd_value), 0);

    // R8: silent while sound timer is zero
    for (int i = 0; i < 4 * DIV; i++) begin
      @(negedge clk);
      check(beep == 1'b0, "R8 beep low", int'(beep), 0);
    end

    // R10: tone write leaves timers alone
    tone_wr = 1'b1; tone_code = 2'd3;
    @(negedge clk);
    tone_wr = 1'b0;
    check(dly_value == 8'd0, "R10 delay unchanged", int'(dly_value), 0);
    check(snd_value == 8'd0, "R10 sound unchanged", int'(snd_value), 0);

    // R9: each tone code sets the half-period
    for (int k = 0; k < 4; k++) begin
      tone_wr = 1'b1; tone_code = 2'(k);
      snd_load = 1'b1; snd_data = 8'd255;
      @(negedge clk);
      tone_wr = 1'b0; snd_load = 1'b0;
      wait_beep_change(span);
      wait_beep_change(span);
      check(span == exp_half(k), "R9 half period", span, exp_half(k));
    end
    load_snd(0);

    // R7: tick spacing seen through a running timer
    load_dly(200);
    wait_beep_change(span);
    saved = int'(dly_value);
    while (int'(dly_value) == saved) @(negedge clk);
    t0 = cyc;
    saved = int'(dly_value);
    while (int'(dly_value) == saved) @(negedge clk);
    check(cyc - t0 == DIV, "R7 tick spacing", cyc - t0, DIV);

    // Constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      dly_load = ($urandom % 16) == 0;
      r = $urandom % 4;
      dly_data = (r == 0) ? 8'd0 : (r == 1) ? 8'd1 : (r == 2) ? 8'd255 : 8'($urandom % 12);
      snd_load = ($urandom % 16) == 0;
      r = $urandom % 4;
      snd_data = (r == 0) ? 8'd0 : (r == 1) ? 8'd1 : (r == 2) ? 8'd255 : 8'($urandom % 12);
      tone_wr = ($urandom % 20) == 0;
      tone_code = 2'($urandom % 4);
      @(negedge clk);
    end
    dly_load = 1'b0; snd_load = 1'b0; tone_wr = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule